// File: doc/BRIEF.md
# Real-Time Clock with Coherent Shadowed Reads

This block keeps wall-clock time for a chip: a seconds counter and a millisecond counter that advance from a slow 32.768 kHz reference. The reference is brought into the fast system clock domain through one two-flop synchronizer, and its rising edges become single-cycle ticks. A fractional accumulator adds the number of milliseconds per second on every tick and subtracts the tick rate whenever it overflows. This advances the millisecond count at exactly the rate the reference sets, with no cumulative drift.

Software reaches the block over a simple synchronous register port with an address, write and read strobes, write data and registered read data. The running counters are not read directly. Once per group of `COPY_TICKS` ticks they are published into bus-visible copies, and a busy flag marks the tick interval that ends in that publish. Register writes are refused while the flag is up. Reading the millisecond register also latches the visible seconds into a shadow register, so a millisecond read followed by a shadow read always yields a matching pair. Two seconds alarms and one millisecond alarm set sticky status bits. Each status bit is cleared by writing a one to it, and a mask turns selected status bits into a level interrupt.

Top module: `rtc_shadow_timer`

## Requirements
- R1: The busy register (offset 0x04, bit 0) reads 1 for exactly one tick interval out of every `COPY_TICKS` ticks. On the tick that ends this interval, the seconds register (0x08) and the millisecond register (0x10) take the running counter values as they stood just before that tick.
- R2: A read of 0x10 returns the visible milliseconds and, in the same access, copies the visible seconds into the shadow register (0x0c). The shadow value changes on no other event.
- R3: A bus write made while busy reads 1 is dropped and alters no register.
- R4: A write to 0x08 loads the running seconds and clears both the millisecond count and the fractional accumulator.
- R5: After n ticks since a seconds load, the elapsed milliseconds equal floor(n·MS_PER_SEC/TICK_HZ). The millisecond field stays within 0..MS_PER_SEC-1 and carries into seconds.
- R6: During a publish, status bit 0 (alarm at 0x14) and status bit 1 (alarm at 0x18) are set when the alarm value is nonzero and equals the running seconds. Status bit 2 (alarm at 0x1c) is set when that alarm equals the running milliseconds. An alarm value of zero never fires a seconds alarm.
- R7: Status (0x2c) bits are cleared by writing 1 and are unchanged by writing 0. The `irq` output is high whenever a status bit and its bit in the mask (0x28, same layout) are both 1.
- R8: The mask register reads back all five bits written. Status bits 3 and 4, the countdown bits, always read 0.
- R9: Read data appears on `busRdata` in the cycle after the read strobe. Offsets outside the map read 0, and writes to them change nothing.
- R10: After reset every register reads 0 except the millisecond alarm, which reads all ones. Both `irq` and busy are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowClk | input | 1 | Asynchronous 32.768 kHz reference |
| busAddr | input | ADDR_W | Register byte offset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, one cycle after the strobe |
| irq | output | 1 | Level interrupt, active high |

## Verification
A wrong phase counter shows up within one publish period, as busy windows that are misplaced or of the wrong length, and the visible time moves with them. A drifting accumulator or a bad carry is visible at the very next publish, because every published pair is compared with the closed-form tick count since the seconds load. A shadow register that follows the live seconds is caught once a second boundary passes between a millisecond read and the matching shadow read. A sticky status bit that is lost, or a stray one, appears on `irq` and the status readback at the following publish.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

  localparam logic [7:0] OFS_BUSY   = 8'h04;
  localparam logic [7:0] OFS_SEC    = 8'h08;
  localparam logic [7:0] OFS_SHADOW = 8'h0C;
  localparam logic [7:0] OFS_MS     = 8'h10;
  localparam logic [7:0] OFS_ALM0   = 8'h14;
  localparam logic [7:0] OFS_ALM1   = 8'h18;
  localparam logic [7:0] OFS_MSALM  = 8'h1C;
  localparam logic [7:0] OFS_MASK   = 8'h28;
  localparam logic [7:0] OFS_STAT   = 8'h2C;

  localparam int SEC_ALARMS = 2;
  localparam int MASK_BITS  = 5;
  localparam int STAT_BITS  = SEC_ALARMS + 1;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_BUSY, SEL_SEC, SEL_SHADOW, SEL_MS,
    SEL_ALM0, SEL_ALM1, SEL_MSALM, SEL_MASK, SEL_STAT
  } rdSel_e;

  typedef struct packed {
    logic                  tick;
    logic                  copy;
    logic                  busy;
    logic                  ldSec;
    logic [SEC_ALARMS-1:0] ldAlm;
    logic                  ldMsAlm;
    logic                  ldMask;
    logic                  clrStatus;
    logic                  capShadow;
    rdSel_e                rdSel;
  } dpCtl_t;

endpackage

// File: rtl/rtc_shadow_ctrl.sv
module rtc_shadow_ctrl
  import rtc_shadow_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int COPY_TICKS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowClk,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output dpCtl_t            ctl
);

  localparam int PH_W = (COPY_TICKS > 1) ? $clog2(COPY_TICKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(COPY_TICKS - 1);

  // Two-flop synchronizer plus one history stage for edge detection.
  logic [2:0] syncQ;
  logic [PH_W-1:0] phase;
  logic tickNow, busyNow, wrOk;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], slowClk};
  end

  assign tickNow = syncQ[1] & ~syncQ[2];

  always_ff @(posedge clk) begin
    if (!rstN)        phase <= '0;
    else if (tickNow) phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
  end

  assign busyNow = (phase == PH_LAST);
  assign wrOk    = busWrEn & ~busyNow;

  function automatic logic isOfs(input logic [7:0] ofs);
    return busAddr == ADDR_W'(ofs);
  endfunction

  always_comb begin
    ctl           = '0;
    ctl.tick      = tickNow;
    ctl.copy      = tickNow & busyNow;
    ctl.busy      = busyNow;
    ctl.ldSec     = wrOk & isOfs(OFS_SEC);
    ctl.ldAlm[0]  = wrOk & isOfs(OFS_ALM0);
    ctl.ldAlm[1]  = wrOk & isOfs(OFS_ALM1);
    ctl.ldMsAlm   = wrOk & isOfs(OFS_MSALM);
    ctl.ldMask    = wrOk & isOfs(OFS_MASK);
    ctl.clrStatus = wrOk & isOfs(OFS_STAT);
    ctl.capShadow = busRdEn & isOfs(OFS_MS);
    ctl.rdSel     = SEL_NONE;
    if (busRdEn) begin
      if      (isOfs(OFS_BUSY))   ctl.rdSel = SEL_BUSY;
      else if (isOfs(OFS_SEC))    ctl.rdSel = SEL_SEC;
      else if (isOfs(OFS_SHADOW)) ctl.rdSel = SEL_SHADOW;
      else if (isOfs(OFS_MS))     ctl.rdSel = SEL_MS;
      else if (isOfs(OFS_ALM0))   ctl.rdSel = SEL_ALM0;
      else if (isOfs(OFS_ALM1))   ctl.rdSel = SEL_ALM1;
      else if (isOfs(OFS_MSALM))  ctl.rdSel = SEL_MSALM;
      else if (isOfs(OFS_MASK))   ctl.rdSel = SEL_MASK;
      else if (isOfs(OFS_STAT))   ctl.rdSel = SEL_STAT;
    end
  end

  // R1: the busy window only ends on a slow tick.
  p_busy_ends_on_tick_r1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyNow) |-> $past(tickNow));

  // R1: between ticks the busy window persists.
  p_busy_holds_r1: assert property (@(posedge clk) disable iff (!rstN)
    busyNow && !tickNow |=> busyNow);

endmodule

// File: rtl/rtc_shadow_dp.sv
module rtc_shadow_dp
  import rtc_shadow_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SEC_W      = 32,
  parameter int TICK_HZ    = 32768,
  parameter int MS_PER_SEC = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);

  localparam int MS_W  = $clog2(MS_PER_SEC);
  localparam int ACC_W = $clog2(TICK_HZ + MS_PER_SEC) + 1;
  localparam logic [MS_W-1:0]  MS_LAST   = MS_W'(MS_PER_SEC - 1);
  localparam logic [ACC_W-1:0] ACC_STEP  = ACC_W'(MS_PER_SEC);
  localparam logic [ACC_W-1:0] ACC_LIMIT = ACC_W'(TICK_HZ);

  logic [SEC_W-1:0]     secCnt, secVis, shadow;
  logic [MS_W-1:0]      msCnt, msVis, msAlm;
  logic [ACC_W-1:0]     acc, accSum;
  logic                 accWrap;
  logic [MASK_BITS-1:0] mask;
  logic [STAT_BITS-1:0] status, statusNext, hits;
  logic [SEC_W-1:0]     secAlm [SEC_ALARMS];
  logic [DATA_W-1:0]    rdNext;

  assign accSum  = acc + ACC_STEP;
  assign accWrap = accSum >= ACC_LIMIT;

  // Running counters: a seconds load takes priority over a tick.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      secCnt <= '0;
      msCnt  <= '0;
      acc    <= '0;
    end else if (ctl.ldSec) begin
      secCnt <= busWdata[SEC_W-1:0];
      msCnt  <= '0;
      acc    <= '0;
    end else if (ctl.tick) begin
      acc <= accWrap ? accSum - ACC_LIMIT : accSum;
      if (accWrap) begin
        if (msCnt == MS_LAST) begin
          msCnt  <= '0;
          secCnt <= secCnt + 1'b1;
        end else begin
          msCnt <= msCnt + 1'b1;
        end
      end
    end
  end

  // Bus-visible copies and the shadow latch.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      secVis <= '0;
      msVis  <= '0;
      shadow <= '0;
    end else begin
      if (ctl.copy) begin
        secVis <= secCnt;
        msVis  <= msCnt;
      end
      if (ctl.capShadow) shadow <= secVis;
    end
  end

  // Seconds alarms: one register and comparator per alarm.
  for (genvar a = 0; a < SEC_ALARMS; a++) begin : gSecAlm
    always_ff @(posedge clk) begin
      if (!rstN)             secAlm[a] <= '0;
      else if (ctl.ldAlm[a]) secAlm[a] <= busWdata[SEC_W-1:0];
    end
    assign hits[a] = (secAlm[a] != '0) && (secAlm[a] == secCnt);
  end

  assign hits[SEC_ALARMS] = (msAlm == msCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msAlm <= '1;
      mask  <= '0;
    end else begin
      if (ctl.ldMsAlm) msAlm <= busWdata[MS_W-1:0];
      if (ctl.ldMask)  mask  <= busWdata[MASK_BITS-1:0];
    end
  end

  always_comb begin
    statusNext = status;
    if (ctl.clrStatus) statusNext = statusNext & ~busWdata[STAT_BITS-1:0];
    if (ctl.copy)      statusNext = statusNext | hits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) status <= '0;
    else       status <= statusNext;
  end

  assign irq = |(status & mask[STAT_BITS-1:0]);

  always_comb begin
    case (ctl.rdSel)
      SEL_BUSY:   rdNext = DATA_W'(ctl.busy);
      SEL_SEC:    rdNext = DATA_W'(secVis);
      SEL_SHADOW: rdNext = DATA_W'(shadow);
      SEL_MS:     rdNext = DATA_W'(msVis);
      SEL_ALM0:   rdNext = DATA_W'(secAlm[0]);
      SEL_ALM1:   rdNext = DATA_W'(secAlm[1]);
      SEL_MSALM:  rdNext = DATA_W'(msAlm);
      SEL_MASK:   rdNext = DATA_W'(mask);
      SEL_STAT:   rdNext = DATA_W'(status);
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= rdNext;
  end

  // R3: configuration registers cannot move during a busy window.
  p_busy_freezes_cfg_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busy |=> $stable(secAlm[0]) && $stable(secAlm[1]) && $stable(msAlm) && $stable(mask));

  // R2: shadow changes only on a millisecond read.
  p_shadow_only_on_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capShadow |=> $stable(shadow));

  // R4: a seconds load restarts the millisecond count.
  p_load_clears_ms_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldSec |=> (msCnt == '0) && (secCnt == $past(busWdata[SEC_W-1:0])));

  // R5: millisecond counter stays in range.
  p_ms_in_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    msCnt <= MS_LAST);

  // R6: a zero seconds alarm never raises its status bit.
  p_zero_alarm_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.copy && (secAlm[0] == '0) && !status[0] |=> !status[0]);

  // R7: the interrupt level holds until status or mask is written.
  p_irq_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq && !ctl.clrStatus && !ctl.ldMask |=> irq);

endmodule

// File: rtl/rtc_shadow_timer.sv
module rtc_shadow_timer
  import rtc_shadow_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int SEC_W      = 32,
  parameter int TICK_HZ    = 32768,
  parameter int MS_PER_SEC = 1000,
  parameter int COPY_TICKS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowClk,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);

  dpCtl_t ctl;

  rtc_shadow_ctrl #(
    .ADDR_W    (ADDR_W),
    .COPY_TICKS(COPY_TICKS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .slowClk (slowClk),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .ctl     (ctl)
  );

  rtc_shadow_dp #(
    .DATA_W    (DATA_W),
    .SEC_W     (SEC_W),
    .TICK_HZ   (TICK_HZ),
    .MS_PER_SEC(MS_PER_SEC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .irq     (irq)
  );

endmodule

// File: tb/rtc_shadow_timer_bench.sv
module rtc_shadow_timer_bench;
  import rtc_shadow_pkg::*;

  localparam int TICK_HZ = 64;
  localparam int MSPS    = 10;
  localparam int COPY    = 8;
  localparam int BASE    = 100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowClk = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  int copies = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  initial begin
    #2;
    forever #32 slowClk = ~slowClk;
  end

  rtc_shadow_timer #(
    .TICK_HZ(TICK_HZ), .MS_PER_SEC(MSPS), .COPY_TICKS(COPY)
  ) u_rtc_shadow_timer (
    .clk(clk), .rstN(rstN), .slowClk(slowClk), .busAddr(busAddr),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdata;
  endtask

  task automatic waitBusyFall();
    logic [31:0] d;
    bit seenHigh = 0;
    forever begin
      busRead(OFS_BUSY, d);
      if (d[0]) seenHigh = 1;
      else if (seenHigh) break;
    end
    copies++;
  endtask

  task automatic waitBusyRise();
    logic [31:0] d;
    forever begin
      busRead(OFS_BUSY, d);
      if (d[0]) break;
    end
  endtask

  // Visible time at the k-th publish after the seconds load: 8k-1 ticks counted.
  task automatic expAt(input int k, output int s, output int m);
    int n, tot;
    n = COPY * k - 1;
    tot = (n * MSPS) / TICK_HZ;
    s = BASE + tot / MSPS;
    m = tot % MSPS;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, msRd, s1;
    int s, m, lastRise, riseCnt, highRun;
    bit prevHigh, st0, st1, st2;
    int alm0, alm1, msAlmV, maskV;

    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R10: reset values
    busRead(OFS_BUSY, d);   chk("R10 busy", d, 0);
    busRead(OFS_SEC, d);    chk("R10 sec", d, 0);
    busRead(OFS_MS, d);     chk("R10 ms", d, 0);
    busRead(OFS_SHADOW, d); chk("R10 shadow", d, 0);
    busRead(OFS_ALM0, d);   chk("R10 alm0", d, 0);
    busRead(OFS_ALM1, d);   chk("R10 alm1", d, 0);
    busRead(OFS_MSALM, d);  chk("R10 msalm", d, 32'hF);
    busRead(OFS_MASK, d);   chk("R10 mask", d, 0);
    busRead(OFS_STAT, d);   chk("R10 status", d, 0);
    chk("R10 irq", {31'd0, irq}, 0);

    // R1: busy window length and spacing, polled every two cycles
    lastRise = -1; riseCnt = 0; highRun = 0; prevHigh = 0;
    for (int i = 0; i < 110; i++) begin
      busRead(OFS_BUSY, d);
      if (d[0] && !prevHigh) begin
        if (lastRise >= 0) chk("R1 busy spacing", i - lastRise, COPY * 4);
        lastRise = i; riseCnt++; highRun = 0;
      end
      if (d[0]) highRun++;
      if (!d[0] && prevHigh) chk("R1 busy length", highRun, 4);
      prevHigh = d[0];
    end
    chk("R1 busy windows seen", riseCnt >= 2, 1);

    // Configure alarms outside a busy window.
    alm0 = BASE + 1; alm1 = 0; msAlmV = 3; maskV = 5;
    waitBusyFall();
    busWrite(OFS_ALM0, alm0);
    busWrite(OFS_ALM1, alm1);
    busWrite(OFS_MSALM, msAlmV);
    busWrite(OFS_MASK, maskV);
    busWrite(OFS_STAT, 32'h7);
    waitBusyFall();
    busWrite(OFS_SEC, BASE);
    copies = 0;
    st0 = 0; st1 = 0; st2 = 0;

    // R1 R4 R5 R6 R7 sweep over twenty publishes
    for (int k = 1; k <= 20; k++) begin
      waitBusyFall();
      expAt(copies, s, m);
      busRead(OFS_MS, msRd);  chk("R4 R5 ms", msRd, m);
      busRead(OFS_SHADOW, d); chk("R2 shadow", d, s);
      busRead(OFS_SEC, d);    chk("R1 R5 sec", d, s);
      st0 |= (alm0 != 0) && (s == alm0);
      st1 |= (alm1 != 0) && (s == alm1);
      st2 |= (m == msAlmV);
      busRead(OFS_STAT, d);
      chk("R6 status", d, {29'd0, st2, st1, st0});
      chk("R8 countdown bits", {30'd0, d[4:3]}, 0);
      chk("R7 irq", {31'd0, irq}, {31'd0, |({st2, st1, st0} & maskV[2:0])});
    end

    // R7: write-one-to-clear inside one quiet window
    waitBusyFall();
    expAt(copies, s, m);
    st2 |= (m == msAlmV);
    busWrite(OFS_STAT, 32'h1);
    busRead(OFS_STAT, d); chk("R7 w1c bit0", d, {29'd0, st2, 2'b00});
    busWrite(OFS_STAT, 32'h0);
    busRead(OFS_STAT, d); chk("R7 write zero", d, {29'd0, st2, 2'b00});
    busWrite(OFS_STAT, 32'h7);
    busRead(OFS_STAT, d); chk("R7 clear all", d, 0);
    chk("R7 irq low", {31'd0, irq}, 0);

    // R2: shadow keeps the seconds of the last millisecond read
    waitBusyFall();
    expAt(copies, s, m);
    busRead(OFS_MS, msRd);   chk("R2 ms", msRd, m);
    busRead(OFS_SHADOW, s1); chk("R2 shadow pair", s1, s);
    for (int k = 0; k < 10; k++) waitBusyFall();
    expAt(copies, s, m);
    busRead(OFS_SEC, d);    chk("R2 sec moved", d, s);
    chk("R2 second advanced", d != s1, 1);
    busRead(OFS_SHADOW, d); chk("R2 shadow held", d, s1);

    // R3: writes during busy are dropped
    waitBusyRise();
    busWrite(OFS_ALM1, 32'h55);
    waitBusyFall();
    busRead(OFS_ALM1, d); chk("R3 alm1 kept", d, 0);
    waitBusyRise();
    busWrite(OFS_SEC, 32'h7);
    waitBusyFall();
    waitBusyFall();
    expAt(copies, s, m);
    busRead(OFS_SEC, d); chk("R3 sec kept", d, s);

    // R8: mask keeps all five bits
    busWrite(OFS_MASK, 32'h1F);
    busRead(OFS_MASK, d); chk("R8 mask readback", d, 32'h1F);

    // R9: undefined offsets
    busRead(8'h20, d); chk("R9 hole read", d, 0);
    busRead(8'h30, d); chk("R9 hole read", d, 0);
    busWrite(8'h24, 32'hFFFF_FFFF);
    busRead(OFS_MASK, d);  chk("R9 mask untouched", d, 32'h1F);
    busRead(OFS_ALM0, d);  chk("R9 alm0 untouched", d, alm0);
    busRead(OFS_MSALM, d); chk("R9 msalm untouched", d, msAlmV);
    @(negedge clk);
    chk("R9 idle data", busRdata, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule